// File: doc/BRIEF.md
# Single-Cycle Eight-Instruction Processor Core

This block is a 32-bit processor core that finishes every instruction in exactly one clock cycle. It executes three-register arithmetic and logic (add, subtract, AND, OR, signed set-less-than), word loads and stores with a base register plus a signed 16-bit displacement, and a branch-if-equal with a word-scaled relative offset. Program and data sit in two separate memories inside the block. A combinational decoder looks at the opcode and function fields and sets the datapath multiplexers: destination-register choice, second ALU operand, write-back source and next-PC source.

The instruction memory has no write path from the core. A testbench or boot agent fills it, and can also preload data words, through a one-word-per-cycle initialisation port while reset is held. After reset is released the core fetches from byte address 0. A debug port shows the current PC and the value of any selected register, so a program's effect can be observed without extra store instructions.

Top module: `sc_core`

## Requirements
- R1: While reset is asserted at a rising edge, the PC becomes 0 and every register becomes 0. The first instruction fetched after reset is the word at byte address 0.
- R2: Every instruction except a taken branch advances the PC by 4 at the next rising edge.
- R3: When opcode bits [31:26] are 0x00, the function field [5:0] selects the operation: 0x20 add, 0x22 subtract (rs minus rt), 0x24 AND, 0x25 OR, 0x2A signed set-less-than giving 1 or 0. Operands come from rs [25:21] and rt [20:16], and the result is written to rd [15:11].
- R4: Register 0 always reads as 0. A write aimed at it has no effect.
- R5: Opcode 0x23 loads into register rt the data word at byte address rs + sign-extended imm[15:0]. Memory words are selected by address bits [N:2].
- R6: Opcode 0x2B stores register rt to the data word at byte address rs + sign-extended imm[15:0]. A store writes no register.
- R7: Opcode 0x04 compares rs and rt. When they are equal, the next PC is PC + 4 + (sign-extended imm << 2), and backward offsets are included. When they differ, the next PC is PC + 4. A branch writes no register.
- R8: Any other opcode, and any function code under opcode 0x00 not listed in R3, writes no register and no memory, and the PC advances by 4.
- R9: An initialisation write stores init_data at word init_addr. It goes to instruction memory when init_to_data is 0 and to data memory when init_to_data is 1. The stored words take effect for fetches and loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| init_we | input | 1 | Initialisation write strobe |
| init_to_data | input | 1 | Initialisation target: 0 instruction memory, 1 data memory |
| init_addr | input | 6 | Initialisation word address |
| init_data | input | 32 | Initialisation word |
| dbg_pc | output | 32 | Current program counter |
| dbg_sel | input | 5 | Register number to show on dbg_val |
| dbg_val | output | 32 | Value of the selected register |

## Verification
The test program mixes operand signs on purpose. A set-less-than compared unsigned would flip both results, and a subtract with its operands swapped would produce +10 instead of -10. Loads use a negative displacement from a nonzero base, which catches an unextended immediate. A store followed by a reload catches a dead or misrouted write enable. The PC trace is scored cycle by cycle through a not-taken branch, a forward taken branch that skips two writes to a watched register, and a backward branch to itself. A wrong target adder, a missing shift by 2 or a reversed Zero test therefore shows up as a wrong PC in a specific cycle. A write to register 0 and two unknown encodings must leave their destinations untouched, and a second reset must clear every register that was written.

// File: rtl/sc_pkg.sv
package sc_pkg;
   localparam int unsigned XLEN   = 32;
   localparam int unsigned NREGS  = 32;
   localparam int unsigned RA_W   = $clog2(NREGS);
   localparam int unsigned IMM_W  = 16;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_LOAD  = 6'h23;
   localparam logic [5:0] OP_STORE = 6'h2B;
   localparam logic [5:0] OP_BEQ   = 6'h04;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [2:0] {
      ALU_AND = 3'd0,
      ALU_OR  = 3'd1,
      ALU_ADD = 3'd2,
      ALU_SUB = 3'd3,
      ALU_SLT = 3'd4
   } alu_op_e;

   typedef struct packed {
      logic    reg_we;   // write register file
      logic    dst_rd;   // 1: destination rd, 0: rt
      logic    b_imm;    // 1: ALU operand B is the immediate
      logic    wb_mem;   // 1: write back memory data
      logic    mem_we;   // write data memory
      logic    branch;   // conditional branch
      alu_op_e alu_op;
   } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
   import sc_pkg::*;
(
   input  logic [5:0] op,
   input  logic [5:0] fn,
   output ctrl_t      ctl
);
   always_comb begin
      ctl        = '0;
      ctl.alu_op = ALU_ADD;
      unique case (op)
         OP_RTYPE: begin
            ctl.dst_rd = 1'b1;
            ctl.reg_we = 1'b1;
            unique case (fn)
               FN_ADD:  ctl.alu_op = ALU_ADD;
               FN_SUB:  ctl.alu_op = ALU_SUB;
               FN_AND:  ctl.alu_op = ALU_AND;
               FN_OR:   ctl.alu_op = ALU_OR;
               FN_SLT:  ctl.alu_op = ALU_SLT;
               default: ctl.reg_we = 1'b0;
            endcase
         end
         OP_LOAD: begin
            ctl.reg_we = 1'b1;
            ctl.b_imm  = 1'b1;
            ctl.wb_mem = 1'b1;
         end
         OP_STORE: begin
            ctl.b_imm  = 1'b1;
            ctl.mem_we = 1'b1;
         end
         OP_BEQ: begin
            ctl.branch = 1'b1;
            ctl.alu_op = ALU_SUB;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int unsigned W = 32
)(
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] y,
   output logic         zero
);
   if (W < 2) begin : g_bad_width
      $error("sc_alu: W must be at least 2");
   end

   always_comb begin
      unique case (op)
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SUB: y = a - b;
         ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter  int unsigned W     = 32,
   parameter  int unsigned NREGS = 32,
   parameter  int unsigned NRD   = 3,
   localparam int unsigned AW    = $clog2(NREGS)
)(
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   we,
   input  logic [AW-1:0]          wa,
   input  logic [W-1:0]           wd,
   input  logic [NRD-1:0][AW-1:0] ra,
   output logic [NRD-1:0][W-1:0]  rdata
);
   if (NREGS < 2 || (1 << AW) != NREGS) begin : g_bad_nregs
      $error("sc_regfile: NREGS must be a power of two of at least 2");
   end
   if (NRD < 1) begin : g_bad_nrd
      $error("sc_regfile: NRD must be at least 1");
   end

   logic [W-1:0] regs [NREGS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      end else if (we && wa != '0) begin
         regs[wa] <= wd;
      end
   end

   for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rdata[g] = regs[ra[g]];

      AST_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
         ra[g] == '0 |-> rdata[g] == '0);   // R4
   end
endmodule

// File: rtl/sc_ram.sv
module sc_ram #(
   parameter  int unsigned DEPTH = 64,
   parameter  int unsigned W     = 32,
   localparam int unsigned AW    = $clog2(DEPTH)
)(
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("sc_ram: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter  int unsigned IMEM_WORDS = 64,
   parameter  int unsigned DMEM_WORDS = 64,
   localparam int unsigned IA = $clog2(IMEM_WORDS),
   localparam int unsigned DA = $clog2(DMEM_WORDS),
   localparam int unsigned LA = (IA > DA) ? IA : DA
)(
   input  logic            clk,
   input  logic            rst,
   input  logic            init_we,
   input  logic            init_to_data,
   input  logic [LA-1:0]   init_addr,
   input  logic [XLEN-1:0] init_data,
   output logic [XLEN-1:0] dbg_pc,
   input  logic [RA_W-1:0] dbg_sel,
   output logic [XLEN-1:0] dbg_val
);
   if (IA + 2 >= XLEN || DA + 2 >= XLEN) begin : g_bad_mem
      $error("sc_core: memory depth exceeds the address space");
   end

   // ---------------- fetch ----------------
   logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target, instr;

   sc_ram #(.DEPTH(IMEM_WORDS), .W(XLEN)) u_imem (
      .clk   (clk),
      .we    (init_we & ~init_to_data),
      .waddr (init_addr[IA-1:0]),
      .wdata (init_data),
      .raddr (pc_q[IA+1:2]),
      .rdata (instr)
   );

   // ---------------- decode ----------------
   logic [5:0]       f_op, f_fn;
   logic [RA_W-1:0]  f_rs, f_rt, f_rd, wa;
   logic [IMM_W-1:0] f_imm;
   logic [XLEN-1:0]  imm_ext;
   ctrl_t            ctl;

   assign f_op    = instr[31:26];
   assign f_rs    = instr[25:21];
   assign f_rt    = instr[20:16];
   assign f_rd    = instr[15:11];
   assign f_fn    = instr[5:0];
   assign f_imm   = instr[IMM_W-1:0];
   assign imm_ext = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};

   sc_decode u_dec (.op(f_op), .fn(f_fn), .ctl(ctl));

   // ---------------- registers ----------------
   logic [2:0][RA_W-1:0] rf_ra;
   logic [2:0][XLEN-1:0] rf_rd;
   logic [XLEN-1:0]      rs_val, rt_val, wd, alu_b, alu_y, dm_rdata;
   logic                 alu_zero, take_br;

   assign rf_ra  = {dbg_sel, f_rt, f_rs};
   assign rs_val = rf_rd[0];
   assign rt_val = rf_rd[1];
   assign wa     = ctl.dst_rd ? f_rd : f_rt;
   assign wd     = ctl.wb_mem ? dm_rdata : alu_y;

   sc_regfile #(.W(XLEN), .NREGS(NREGS), .NRD(3)) u_rf (
      .clk   (clk),
      .rst   (rst),
      .we    (ctl.reg_we),
      .wa    (wa),
      .wd    (wd),
      .ra    (rf_ra),
      .rdata (rf_rd)
   );

   // ---------------- execute ----------------
   assign alu_b = ctl.b_imm ? imm_ext : rt_val;

   sc_alu #(.W(XLEN)) u_alu (
      .a    (rs_val),
      .b    (alu_b),
      .op   (ctl.alu_op),
      .y    (alu_y),
      .zero (alu_zero)
   );

   // ---------------- data memory ----------------
   logic            dm_init, dm_we;
   logic [DA-1:0]   dm_waddr;
   logic [XLEN-1:0] dm_wdata;

   assign dm_init  = init_we & init_to_data;
   assign dm_we    = dm_init | (ctl.mem_we & ~rst);
   assign dm_waddr = dm_init ? init_addr[DA-1:0] : alu_y[DA+1:2];
   assign dm_wdata = dm_init ? init_data : rt_val;

   sc_ram #(.DEPTH(DMEM_WORDS), .W(XLEN)) u_dmem (
      .clk   (clk),
      .we    (dm_we),
      .waddr (dm_waddr),
      .wdata (dm_wdata),
      .raddr (alu_y[DA+1:2]),
      .rdata (dm_rdata)
   );

   // ---------------- next PC ----------------
   assign pc_plus4  = pc_q + XLEN'(4);
   assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
   assign take_br   = ctl.branch & alu_zero;
   assign pc_next   = take_br ? br_target : pc_plus4;

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_next;
   end

   assign dbg_pc  = pc_q;
   assign dbg_val = rf_rd[2];

   logic unused_bits;
   assign unused_bits = ^{pc_q[1:0], pc_q[XLEN-1:IA+2], alu_y[1:0],
                          alu_y[XLEN-1:DA+2], instr[10:6]};

   // ---------------- assertions ----------------
   AST_PC_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> pc_q == '0);                                   // R1
   AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(take_br)) |-> pc_q == $past(pc_q) + XLEN'(4)); // R2
   AST_PC_BRANCH: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(take_br)) |-> pc_q == $past(br_target)); // R7
   AST_BRANCH_EQUAL: assert property (@(posedge clk) disable iff (rst)
      take_br |-> rs_val == rt_val);                                // R7
   AST_SINGLE_EFFECT: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ctl.reg_we, ctl.mem_we, ctl.branch}));              // R6
endmodule

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
   import sc_pkg::*;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        init_we = 1'b0;
   logic        init_to_data = 1'b0;
   logic [5:0]  init_addr = '0;
   logic [31:0] init_data = '0;
   logic [4:0]  dbg_sel = '0;
   logic [31:0] dbg_pc, dbg_val;

   always #2 clk = ~clk;   // 250 MHz

   sc_core uut (
      .clk(clk), .rst(rst), .init_we(init_we), .init_to_data(init_to_data),
      .init_addr(init_addr), .init_data(init_data),
      .dbg_pc(dbg_pc), .dbg_sel(dbg_sel), .dbg_val(dbg_val)
   );

   typedef struct {
      logic [4:0]  idx;
      logic [31:0] val;
      string       tag;
   } exp_t;

   exp_t pcq[$];
   exp_t regq[$];
   int   n_chk = 0;
   int   n_err = 0;
   bit   mon_en = 1'b0;
   bit   done = 1'b0;

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] r_ins(int rs, int rt, int rd, logic [5:0] fn);
      return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
   endfunction

   function automatic logic [31:0] i_ins(logic [5:0] op, int rs, int rt, int imm);
      return {op, rs[4:0], rt[4:0], imm[15:0]};
   endfunction

   task automatic load_word(bit to_data, int addr, logic [31:0] data);
      @(negedge clk);
      init_we      = 1'b1;
      init_to_data = to_data;
      init_addr    = addr[5:0];
      init_data    = data;
      @(negedge clk);
      init_we      = 1'b0;
   endtask

   task automatic push_pc(logic [31:0] v, string tag);
      exp_t e;
      e.idx = '0; e.val = v; e.tag = tag;
      pcq.push_back(e);
   endtask

   task automatic push_reg(int idx, logic [31:0] v, string tag);
      exp_t e;
      e.idx = idx[4:0]; e.val = v; e.tag = tag;
      regq.push_back(e);
   endtask

   // Monitor: scores the PC once per cycle, 1 ns after the falling edge.
   always begin
      @(negedge clk);
      #1;
      if (mon_en && pcq.size() > 0) begin
         exp_t e;
         e = pcq.pop_front();
         check(e.tag, "pc", dbg_pc, e.val);
      end
   end

   // Register monitor: drains the register scoreboard through the debug port.
   task automatic drain_regs();
      while (regq.size() > 0) begin
         exp_t e;
         e = regq.pop_front();
         @(negedge clk);
         dbg_sel = e.idx;
         #1;
         check(e.tag, $sformatf("reg%0d", e.idx), dbg_val, e.val);
      end
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      // R9: fill instruction memory with zero (an unlisted function code, R8)
      for (int i = 0; i < 64; i++) load_word(1'b0, i, 32'h0);
      // R9: data preload
      load_word(1'b1, 0, 32'h0000_0007);
      load_word(1'b1, 1, 32'hFFFF_FFFD);
      load_word(1'b1, 2, 32'h0F0F_00FF);
      load_word(1'b1, 4, 32'hDEAD_BEEF);
      // program
      load_word(1'b0,  0, i_ins(OP_LOAD, 0, 1, 0));
      load_word(1'b0,  1, i_ins(OP_LOAD, 0, 2, 4));
      load_word(1'b0,  2, i_ins(OP_LOAD, 0, 3, 8));
      load_word(1'b0,  3, r_ins(1, 2, 4, FN_ADD));
      load_word(1'b0,  4, r_ins(2, 1, 5, FN_SUB));
      load_word(1'b0,  5, r_ins(3, 2, 6, FN_AND));
      load_word(1'b0,  6, r_ins(1, 5, 7, FN_OR));
      load_word(1'b0,  7, r_ins(2, 1, 8, FN_SLT));
      load_word(1'b0,  8, r_ins(1, 2, 9, FN_SLT));
      load_word(1'b0,  9, r_ins(1, 1, 0, FN_ADD));
      load_word(1'b0, 10, i_ins(OP_STORE, 0, 4, 16));
      load_word(1'b0, 11, i_ins(OP_LOAD, 0, 10, 16));
      load_word(1'b0, 12, i_ins(OP_LOAD, 1, 11, -3));
      load_word(1'b0, 13, i_ins(OP_BEQ, 1, 2, 5));
      load_word(1'b0, 14, i_ins(OP_BEQ, 4, 10, 2));
      load_word(1'b0, 15, r_ins(1, 1, 13, FN_ADD));
      load_word(1'b0, 16, r_ins(1, 1, 13, FN_ADD));
      load_word(1'b0, 17, {6'h3F, 5'd1, 5'd1, 5'd13, 5'd0, 6'h20});
      load_word(1'b0, 18, r_ins(1, 1, 13, 6'h27));
      load_word(1'b0, 19, i_ins(OP_BEQ, 0, 0, -1));

      // R1: state while reset is held
      @(negedge clk);
      dbg_sel = 5'd4;
      #1;
      check("R1", "pc in reset", dbg_pc, 32'h0);
      check("R1", "reg4 in reset", dbg_val, 32'h0);

      // Expected PC trace
      push_pc(32'd0, "R1");
      for (int w = 1; w <= 13; w++) push_pc(32'(w * 4), "R2");
      push_pc(32'd56, "R7");  // not-taken branch at word 13
      push_pc(32'd68, "R7");  // taken forward branch to word 17
      push_pc(32'd72, "R8");  // unknown opcode steps by 4
      push_pc(32'd76, "R8");  // unknown function code steps by 4
      push_pc(32'd76, "R7");  // backward branch to itself
      push_pc(32'd76, "R7");

      @(negedge clk);
      rst    = 1'b0;
      mon_en = 1'b1;
      while (pcq.size() > 0) @(negedge clk);
      mon_en = 1'b0;

      push_reg(1,  32'h0000_0007, "R5");
      push_reg(2,  32'hFFFF_FFFD, "R5");
      push_reg(3,  32'h0F0F_00FF, "R9");
      push_reg(4,  32'h0000_0004, "R3");
      push_reg(5,  32'hFFFF_FFF6, "R3");
      push_reg(6,  32'h0F0F_00FD, "R3");
      push_reg(7,  32'hFFFF_FFF7, "R3");
      push_reg(8,  32'h0000_0001, "R3");
      push_reg(9,  32'h0000_0000, "R3");
      push_reg(0,  32'h0000_0000, "R4");
      push_reg(10, 32'h0000_0004, "R6");
      push_reg(11, 32'hFFFF_FFFD, "R5");
      push_reg(13, 32'h0000_0000, "R8");
      drain_regs();

      // R1: second reset clears everything written
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      #1;
      check("R1", "pc after reset", dbg_pc, 32'h0);
      for (int r = 1; r <= 11; r++) push_reg(r, 32'h0, "R1");
      drain_regs();

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule